// File: doc/BRIEF.md
# Word-Register I2C Target Front End

This block lets an I2C host reach a small bank of 16-bit registers. The host sends a one-byte command code that selects a register. A word write then delivers two data bytes. A word read changes direction with a repeated start and receives two bytes. In both directions the byte holding bits 7:0 travels first. The block answers only at its fixed 7-bit address.

Toward the core, the block presents one configuration word, which the host may write and read back. It also samples a set of result words that the core supplies and the host may only read. The block drives SDA open-drain: the output only tells the pad when to pull the line low.

SCL and SDA are oversampled by the system clock through a short synchroniser. If either line stays low for too long, the bus logic returns to idle and lets go of SDA.

Top module: `i2cw_slave`

## Requirements
- R1: A 7-bit address of 0x10 with the write direction bit (bit 0 = 0) is acknowledged. Every other 7-bit address is not acknowledged, and SDA is left released.
- R2: After reset the configuration word is 0x0000 and SDA is released. A word write to command code 0x00 places {second data byte, first data byte} & mask on `conf_q` once the second data byte has been acknowledged.
- R3: Only bits 6:4 and 2:0 of the configuration word are writable (mask 0x0077). All other bits always read as zero.
- R4: A word write to any command code other than 0x00 is acknowledged and leaves the configuration word unchanged.
- R5: A word read is made of a start, address+write, the command code, a repeated start, and address+read (bit 0 = 1). It returns bits 7:0 of the selected word, then bits 15:8. Code 0x00 returns the configuration word. Codes 0x08 to 0x0B return result channels 0 to 3, where channel i is `res_in[16*i+15:16*i]`. Every other code returns 0x0000.
- R6: An address+read that follows a stop, with no command code sent since that stop, is not acknowledged.
- R7: A write that ends with a stop right after its first data byte leaves the configuration word unchanged.
- R8: The second byte of a read comes from the same capture of the selected word as the first byte, even if the core input changes between the two bytes.
- R9: A stop condition releases SDA on the next cycle. So does either line being held low for `TIMEOUT_CYC` cycles, after which the block waits for a new start.
- R10: The block starts pulling SDA low only while SCL is low. Its SDA output holds steady through every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| res_in | input | NUM_RES*16 | Result words from the core, channel 0 in the low bits |
| conf_q | output | 16 | Configuration word toward the core |

## Verification
Every one of the 128 seven-bit addresses is tried. This shows that the acknowledge depends on the full address and not on a subset of its bits.

Word writes use varied bit patterns, so that the writable mask and the byte order are confirmed both on `conf_q` and by reading the word back. A read of every command code from 0x00 to 0x0F separates the mapped locations from the ones that return zero.

Four targeted sequences cover the remaining cases:
- a read attempted straight after a stop;
- a write cut off after its first data byte;
- a result word that changes between the two read bytes;
- SCL held low while the block is driving a data bit.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [BYTE_W-1:0] CONF_CMD = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WLO, ST_WLO_ACK, ST_WHI, ST_WHI_ACK,
    ST_RLO, ST_RLO_MACK, ST_RHI, ST_RHI_MACK, ST_SKIP
  } bus_st_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '1;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cw_lowwatch.sv
module i2cw_lowwatch #(
  parameter int LIMIT = 750000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (scl_s && sda_s) begin
        cnt <= '0;
      end else if (cnt != CW'(LIMIT)) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(LIMIT - 1)) expire <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs import i2cw_pkg::*; #(
  parameter int                NUM_RES  = 4,
  parameter int                RES_BASE = 8,
  parameter logic [WORD_W-1:0] WMASK    = 16'h0077
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [BYTE_W-1:0]         wr_ptr,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic [BYTE_W-1:0]         rd_ptr,
  input  logic [NUM_RES*WORD_W-1:0] res_in,
  output logic [WORD_W-1:0]         conf_q,
  output logic [WORD_W-1:0]         rd_q
);
  logic [WORD_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) conf_q <= '0;
    else if (wr_en && wr_ptr == CONF_CMD) conf_q <= wr_data & WMASK;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_ptr == CONF_CMD) rd_mux = conf_q;
    for (int i = 0; i < NUM_RES; i++)
      if (rd_ptr == BYTE_W'(RES_BASE + i)) rd_mux = res_in[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave import i2cw_pkg::*; #(
  parameter logic [6:0]        SLV_ADDR    = 7'h10,
  parameter int                NUM_RES     = 4,
  parameter int                RES_BASE    = 8,
  parameter logic [WORD_W-1:0] WMASK       = 16'h0077,
  parameter int                TIMEOUT_CYC = 750000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe,
  input  logic [NUM_RES*WORD_W-1:0] res_in,
  output logic [WORD_W-1:0]         conf_q
);
  logic [1:0] lines_s;
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, start_c, stop_c, tmo;

  bus_st_t           st;
  logic [CNT_W-1:0]  bcnt;
  logic [BYTE_W-1:0] sr, ptr, lo_byte, txsr, hi_hold;
  logic              cmd_seen, rd_dir, mack;
  logic              wr_en;
  logic [WORD_W-1:0] wr_data, rd_q;

  i2cw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(lines_s));

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cw_lowwatch #(.LIMIT(TIMEOUT_CYC)) u_watch (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .expire(tmo));

  i2cw_regs #(.NUM_RES(NUM_RES), .RES_BASE(RES_BASE), .WMASK(WMASK)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ptr(ptr), .wr_data(wr_data),
    .rd_ptr(ptr), .res_in(res_in), .conf_q(conf_q), .rd_q(rd_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  bcnt <= '0;  sr <= '0;  sda_oe <= 1'b0;
      ptr <= '0;  lo_byte <= '0;  txsr <= '0;  hi_hold <= '0;
      cmd_seen <= 1'b0;  rd_dir <= 1'b0;  mack <= 1'b0;
      wr_en <= 1'b0;  wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (tmo || stop_c) begin
        st <= ST_IDLE;  sda_oe <= 1'b0;  cmd_seen <= 1'b0;
      end else if (start_c) begin
        st <= ST_ADDR;  bcnt <= '0;  sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_CMD, ST_WLO, ST_WHI: begin
            if (scl_rise) begin
              sr   <= {sr[BYTE_W-2:0], sda_s};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == CNT_W'(BYTE_W)) begin
              sda_oe <= 1'b1;
              case (st)
                ST_ADDR: begin
                  if (sr[BYTE_W-1:1] == SLV_ADDR && (!sr[0] || cmd_seen)) begin
                    rd_dir <= sr[0];
                    st     <= ST_ADDR_ACK;
                  end else begin
                    sda_oe <= 1'b0;
                    st     <= ST_SKIP;
                  end
                end
                ST_CMD: begin
                  ptr <= sr;  cmd_seen <= 1'b1;  st <= ST_CMD_ACK;
                end
                ST_WLO: begin
                  lo_byte <= sr;  st <= ST_WLO_ACK;
                end
                default: begin
                  wr_en <= 1'b1;  wr_data <= {sr, lo_byte};  st <= ST_WHI_ACK;
                end
              endcase
            end
          end
          ST_ADDR_ACK, ST_CMD_ACK, ST_WLO_ACK, ST_WHI_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bcnt   <= '0;
              case (st)
                ST_ADDR_ACK: begin
                  if (rd_dir) begin
                    txsr    <= rd_q[BYTE_W-1:0];
                    hi_hold <= rd_q[WORD_W-1:BYTE_W];
                    sda_oe  <= ~rd_q[BYTE_W-1];
                    bcnt    <= CNT_W'(1);
                    st      <= ST_RLO;
                  end else begin
                    st <= ST_CMD;
                  end
                end
                ST_CMD_ACK: st <= ST_WLO;
                ST_WLO_ACK: st <= ST_WHI;
                default:    st <= ST_SKIP;
              endcase
            end
          end
          ST_RLO, ST_RHI: begin
            if (scl_fall) begin
              if (bcnt == CNT_W'(BYTE_W)) begin
                sda_oe <= 1'b0;
                st     <= (st == ST_RLO) ? ST_RLO_MACK : ST_RHI_MACK;
              end else begin
                sda_oe <= ~txsr[BYTE_W-2];
                txsr   <= txsr << 1;
                bcnt   <= bcnt + 1'b1;
              end
            end
          end
          ST_RLO_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                txsr   <= hi_hold;
                sda_oe <= ~hi_hold[BYTE_W-1];
                bcnt   <= CNT_W'(1);
                st     <= ST_RHI;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_RHI_MACK: if (scl_fall) st <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cw_slave_chk.sv
module i2cw_slave_chk #(
  parameter logic [15:0] WMASK = 16'h0077
) (
  input logic        clk,
  input logic        rst,
  input logic        scl_s,
  input logic        sda_oe,
  input logic        stop_c,
  input logic        tmo,
  input logic        wr_en,
  input logic [7:0]  wr_ptr,
  input logic [15:0] conf_q
);
  assert_drive_in_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> !sda_oe);

  assert_timeout_release_R9: assert property (@(posedge clk) disable iff (rst)
    tmo |=> !sda_oe);

  assert_conf_guard_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(conf_q) |-> ($past(wr_en) && $past(wr_ptr) == 8'h00));

  assert_resv_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (conf_q & ~WMASK) == 16'h0000);
endmodule

bind i2cw_slave i2cw_slave_chk #(.WMASK(WMASK)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .stop_c(stop_c),
  .tmo(tmo), .wr_en(wr_en), .wr_ptr(ptr), .conf_q(conf_q));

// File: tb/sim_i2cw_slave.sv
module sim_i2cw_slave;
  localparam int TMO = 2000;
  localparam int Q   = 6;
  localparam int H   = 12;
  localparam logic [15:0] MASK = 16'h0077;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [63:0] res_in;
  logic [15:0] conf_q;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  logic [15:0] conf_exp = 16'h0000;

  always #2 clk = ~clk;

  i2cw_slave #(.TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .res_in(res_in), .conf_q(conf_q));

  task automatic wait_c(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1; scl_m = 1; wait_c(H);
    sda_m = 0; wait_c(H);
    scl_m = 0; wait_c(Q);
  endtask

  task automatic bus_rstart;
    sda_m = 1; wait_c(Q);
    scl_m = 1; wait_c(H);
    sda_m = 0; wait_c(H);
    scl_m = 0; wait_c(Q);
  endtask

  task automatic bus_stop;
    sda_m = 0; wait_c(Q);
    scl_m = 1; wait_c(H);
    sda_m = 1; wait_c(H);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_c(Q);
      scl_m = 1; wait_c(H);
      scl_m = 0; wait_c(Q);
    end
    sda_m = 1; wait_c(Q);
    scl_m = 1; wait_c(H/2);
    ack = !sda_line;
    wait_c(H/2);
    scl_m = 0; wait_c(Q);
  endtask

  task automatic get_byte(output logic [7:0] b, input bit host_ack, inout bit steady);
    logic s0;
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wait_c(Q);
      scl_m = 1; wait_c(1);
      s0 = sda_line;
      wait_c(H-1);
      if (sda_line !== s0) steady = 0;
      b[i] = sda_line;
      scl_m = 0;
    end
    wait_c(Q);
    sda_m = host_ack ? 1'b0 : 1'b1; wait_c(Q);
    scl_m = 1; wait_c(H);
    scl_m = 0; wait_c(Q);
    sda_m = 1;
  endtask

  task automatic wr_word(input logic [7:0] cmd, input logic [15:0] w, output bit all_ack);
    bit a0, a1, a2, a3;
    bus_start;
    put_byte(8'h20, a0);
    put_byte(cmd, a1);
    put_byte(w[7:0], a2);
    put_byte(w[15:8], a3);
    bus_stop;
    all_ack = a0 & a1 & a2 & a3;
  endtask

  bit        swap_mid = 0;
  logic [63:0] swap_val;

  task automatic rd_word(input logic [7:0] cmd, output logic [15:0] w,
                         output bit all_ack, inout bit steady);
    bit a0, a1, a2;
    logic [7:0] lo, hi;
    bus_start;
    put_byte(8'h20, a0);
    put_byte(cmd, a1);
    bus_rstart;
    put_byte(8'h21, a2);
    get_byte(lo, 1'b1, steady);
    if (swap_mid) res_in = swap_val;
    get_byte(hi, 1'b0, steady);
    bus_stop;
    w = {hi, lo};
    all_ack = a0 & a1 & a2;
  endtask

  function automatic logic [15:0] model_rd(input logic [7:0] cmd);
    if (cmd == 8'h00) return conf_exp;
    if (cmd >= 8'h08 && cmd <= 8'h0B) return res_in[(cmd - 8'h08)*16 +: 16];
    return 16'h0000;
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary;
    $finish;
  end

  initial begin
    bit ok, steady;
    logic [15:0] w, exp;
    logic [7:0] wcmds [6];

    res_in = {16'h4567, 16'h3456, 16'h9AC5, 16'h1234};
    wait_c(10);
    rst = 0;
    wait_c(5);
    check(sda_oe == 1'b0 && conf_q == 16'h0000, "R2 reset state",
          {15'h0, sda_oe, conf_q}, 32'h0);

    // R1: exhaustive address sweep
    for (int a = 0; a < 128; a++) begin
      bus_start;
      put_byte({a[6:0], 1'b0}, ok);
      bus_stop;
      check(ok == (a == 16), "R1 address ack", {31'h0, ok}, {31'h0, a == 16});
    end

    // R2/R3/R5: write patterns, check port and read back
    steady = 1;
    for (int k = 0; k < 8; k++) begin
      w = 16'(k * 16'h2B49) ^ 16'hA5C3;
      wr_word(8'h00, w, ok);
      conf_exp = w & MASK;
      check(ok && conf_q == conf_exp, "R2 conf write", {15'h0, ok, conf_q}, {16'h1, conf_exp});
      check((conf_q & ~MASK) == 16'h0, "R3 reserved bits zero", {16'h0, conf_q & ~MASK}, 32'h0);
      rd_word(8'h00, w, ok, steady);
      check(ok && w == conf_exp, "R5 conf readback", {15'h0, ok, w}, {16'h1, conf_exp});
    end

    // R4: writes elsewhere leave conf unchanged
    wcmds = '{8'h01, 8'h07, 8'h08, 8'h0B, 8'h0C, 8'hFF};
    foreach (wcmds[j]) begin
      wr_word(wcmds[j], 16'hFFFF, ok);
      check(ok && conf_q == conf_exp, "R4 other code write ignored",
            {15'h0, ok, conf_q}, {16'h1, conf_exp});
    end

    // R5: read every command code 0x00..0x0F
    for (int c = 0; c < 16; c++) begin
      rd_word(8'(c), w, ok, steady);
      exp = model_rd(8'(c));
      check(ok && w == exp, "R5 word read", {15'h0, ok, w}, {16'h1, exp});
    end
    check(steady, "R10 SDA steady while SCL high", {31'h0, steady}, 32'h1);

    // R6: read after a stop with no command
    bus_start;
    put_byte(8'h21, ok);
    bus_stop;
    check(!ok, "R6 read without command nacked", {31'h0, ok}, 32'h0);

    // R7: write cut off after the first data byte
    bus_start;
    put_byte(8'h20, ok);
    put_byte(8'h00, ok);
    put_byte(8'h55, ok);
    bus_stop;
    check(conf_q == conf_exp, "R7 truncated write", {16'h0, conf_q}, {16'h0, conf_exp});

    // R8: channel 1 changes between the two read bytes
    swap_val = {res_in[63:32], 16'h17E8, res_in[15:0]};
    swap_mid = 1;
    rd_word(8'h09, w, ok, steady);
    swap_mid = 0;
    check(ok && w == 16'h9AC5, "R8 word snapshot", {15'h0, ok, w}, {16'h1, 16'h9AC5});

    // R9: SCL held low while the block drives a zero bit
    bus_start;
    put_byte(8'h20, ok);
    put_byte(8'h08, ok);
    bus_rstart;
    put_byte(8'h21, ok);
    check(sda_oe == 1'b1, "R9 block driving before timeout", {31'h0, sda_oe}, 32'h1);
    wait_c(TMO + 50);
    check(sda_oe == 1'b0, "R9 released after timeout", {31'h0, sda_oe}, 32'h0);
    sda_m = 1; scl_m = 1; wait_c(H);
    rd_word(8'h0A, w, ok, steady);
    check(ok && w == 16'h3456, "R9 recovery read", {15'h0, ok, w}, {16'h1, 16'h3456});
    check(steady, "R10 SDA steady after recovery", {31'h0, steady}, 32'h1);

    summary;
    $finish;
  end
endmodule